// File: doc/BRIEF.md
# Clock-Rate Time-Slot Scheduler

This block sequences one slow-rate region of logic that is executed on a much faster clock. A single step counter runs from zero up to the cycle budget minus one and then wraps, so one full lap of the counter spans exactly one slow-rate sample period. Each scheduled sub-unit gets its own enable output. That enable is high only while the counter sits inside a fixed inclusive window of steps.

Dependent multi-cycle units therefore run one after another in latency order within each slow-rate period, all driven by the same shared counter. A sample-start flag marks step zero, where a new slow-rate sample begins. The window bounds and the budget are elaboration parameters. A window whose start lies after its end, or whose end reaches past the last step, stops elaboration with an error.

A global clock enable freezes the counter, which also freezes every enable.

Top module: `slot_sched`

## Requirements
- R1: While reset is high, the step counter is forced to 0 on each clock edge. The step output reads 0 after the first edge with reset high. At that point the sample-start output is 1, and every unit whose window starts at step 0 is enabled at once.
- R2: With the clock enable high and reset low, the step value rises by one on each clock edge. After step BUDGET-1 it returns to 0. It never shows a value above BUDGET-1.
- R3: For every unit u, the enable bit u of `unit_en` is 1 exactly when the current step is at least that unit's start step and at most its end step, with both bounds included.
- R4: With the default parameters, BUDGET is 30 and there are four units. Their windows are [0,1] for unit 0, [1,4] for unit 1, [2,3] for unit 2 and [4,7] for unit 3. Unit u drives bit u of `unit_en`.
- R5: While the clock enable is low and reset is low, the step value holds across clock edges, so every enable output and the sample-start output also hold.
- R6: `sample_start` is 1 exactly when the step value is 0. With the clock enable held high, this gives a one-cycle pulse once every BUDGET cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Global clock enable; the counter advances only while this is high |
| step | output | STEP_W | Current step within the slow-rate period |
| unit_en | output | NUM_UNITS | One enable per scheduled unit, high inside its window |
| sample_start | output | 1 | High while the step is 0 |

## Verification
The hardest situations to reach are a freeze that lands exactly on a window edge or on the wrap step, and a reset that arrives while some window is half-way through. With the clock enable toggling in an irregular pattern, a free-running lap passes through every window boundary and holds on it. The bench therefore applies such a pattern over several full laps, then a long freeze, and then a reset in the middle of a lap. A behavioural step model, advanced on the same edges, supplies the expected step, enables and start flag on every cycle.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;

    localparam int unsigned BOUND_W    = 8;
    localparam int unsigned MAX_BUDGET = 1 << BOUND_W;

    typedef struct packed {
        logic [BOUND_W-1:0] first;
        logic [BOUND_W-1:0] last;
    } slot_window_t;

    function automatic int unsigned step_width(input int unsigned budget);
        return (budget <= 2) ? 1 : $clog2(budget);
    endfunction

    function automatic bit window_legal(input slot_window_t w, input int unsigned budget);
        return (w.first <= w.last) && (int'(w.last) <= int'(budget) - 1);
    endfunction

endpackage

// File: rtl/slot_step_counter.sv
module slot_step_counter #(
    parameter int unsigned BUDGET = 30,
    parameter int unsigned STEP_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    output logic [STEP_W-1:0] step,
    output logic              at_origin
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(BUDGET - 1);

    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] step_d;

    always_comb begin
        step_d = step_q;
        if (clk_en) begin
            if (step_q == LAST_STEP) step_d = '0;
            else                     step_d = step_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= '0;
        else     step_q <= step_d;
    end

    assign step      = step_q;
    assign at_origin = (step_q == '0);
endmodule

// File: rtl/slot_window_decode.sv
module slot_window_decode #(
    parameter int unsigned STEP_W  = 5,
    parameter int unsigned FIRST   = 0,
    parameter int unsigned LAST    = 0,
    parameter int unsigned TOP     = 29
) (
    input  logic [STEP_W-1:0] step,
    output logic              active
);
    localparam logic [STEP_W-1:0] FIRST_S = STEP_W'(FIRST);
    localparam logic [STEP_W-1:0] LAST_S  = STEP_W'(LAST);
    localparam int unsigned       ALL_ONE = (1 << STEP_W) - 1;

    logic above_first;
    logic below_last;

    generate
        if (FIRST == 0) begin : g_open_low
            assign above_first = 1'b1;
        end else begin : g_cmp_low
            assign above_first = (step >= FIRST_S);
        end

        if (LAST >= TOP && TOP == ALL_ONE) begin : g_open_high
            assign below_last = 1'b1;
        end else begin : g_cmp_high
            assign below_last = (step <= LAST_S);
        end
    endgenerate

    assign active = above_first && below_last;
endmodule

// File: rtl/slot_sched.sv
module slot_sched
    import slot_sched_pkg::*;
#(
    parameter int unsigned  BUDGET    = 30,
    parameter int unsigned  NUM_UNITS = 4,
    parameter slot_window_t WINDOWS [NUM_UNITS] = '{
        '{first: 8'd0, last: 8'd1},
        '{first: 8'd1, last: 8'd4},
        '{first: 8'd2, last: 8'd3},
        '{first: 8'd4, last: 8'd7}
    },
    localparam int unsigned STEP_W = step_width(BUDGET)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clk_en,
    output logic [STEP_W-1:0]    step,
    output logic [NUM_UNITS-1:0] unit_en,
    output logic                 sample_start
);
    generate
        if (BUDGET < 2 || BUDGET > MAX_BUDGET) begin : g_bad_budget
            $error("slot_sched: BUDGET out of range");
        end
    endgenerate

    logic [STEP_W-1:0] step_w;

    slot_step_counter #(
        .BUDGET (BUDGET),
        .STEP_W (STEP_W)
    ) u_counter (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .step      (step_w),
        .at_origin (sample_start)
    );

    generate
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
            if (!window_legal(WINDOWS[u], BUDGET)) begin : g_bad_window
                $error("slot_sched: illegal window for a unit");
            end
            slot_window_decode #(
                .STEP_W (STEP_W),
                .FIRST  (int'(WINDOWS[u].first)),
                .LAST   (int'(WINDOWS[u].last)),
                .TOP    (BUDGET - 1)
            ) u_win (
                .step   (step_w),
                .active (unit_en[u])
            );
        end
    endgenerate

    assign step = step_w;
endmodule

// File: rtl/slot_sched_chk.sv
module slot_sched_chk
    import slot_sched_pkg::*;
#(
    parameter int unsigned  BUDGET    = 30,
    parameter int unsigned  NUM_UNITS = 4,
    parameter slot_window_t WINDOWS [NUM_UNITS] = '{
        '{first: 8'd0, last: 8'd1},
        '{first: 8'd1, last: 8'd4},
        '{first: 8'd2, last: 8'd3},
        '{first: 8'd4, last: 8'd7}
    },
    localparam int unsigned STEP_W = step_width(BUDGET)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 clk_en,
    input logic [STEP_W-1:0]    step,
    input logic [NUM_UNITS-1:0] unit_en,
    input logic                 sample_start
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(BUDGET - 1);

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (step == '0 && sample_start));

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (clk_en && step == LAST_STEP) |=> (step == '0));

    assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (clk_en && step != LAST_STEP) |=> (step == STEP_W'($past(step) + 1'b1)));

    assert_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        step <= LAST_STEP);

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(step) && $stable(unit_en) && $stable(sample_start)));

    assert_start_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sample_start) |-> ($past(step) == LAST_STEP || $past(rst)));

    generate
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_win
            assert_window_open_R3: assert property (@(posedge clk) disable iff (rst)
                $rose(unit_en[u]) |-> (step == STEP_W'(WINDOWS[u].first)));
            assert_window_close_R3: assert property (@(posedge clk) disable iff (rst)
                $fell(unit_en[u]) |-> ($past(step) == STEP_W'(WINDOWS[u].last) || $past(rst)));
        end
    endgenerate
endmodule

bind slot_sched slot_sched_chk #(
    .BUDGET    (BUDGET),
    .NUM_UNITS (NUM_UNITS),
    .WINDOWS   (WINDOWS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .clk_en       (clk_en),
    .step         (step),
    .unit_en      (unit_en),
    .sample_start (sample_start)
);

// File: tb/test_slot_sched.sv
module test_slot_sched;
    localparam int BUDGET = 30;
    localparam int UNITS  = 4;
    localparam int STEP_W = 5;

    int win_lo [UNITS] = '{0, 1, 2, 4};
    int win_hi [UNITS] = '{1, 4, 3, 7};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clk_en = 1'b0;
    logic [STEP_W-1:0] step;
    logic [UNITS-1:0]  unit_en;
    logic              sample_start;

    int checks = 0;
    int failures = 0;
    int model_step = -1;
    bit last_rst = 1'b0;
    bit last_ce  = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    slot_sched i_slot_sched (
        .clk          (clk),
        .rst          (rst),
        .clk_en       (clk_en),
        .step         (step),
        .unit_en      (unit_en),
        .sample_start (sample_start)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: step position within the slow-rate period
    always @(posedge clk) begin
        last_rst = rst;
        last_ce  = clk_en;
        if (rst)                 model_step = 0;
        else if (model_step < 0) model_step = -1;
        else if (clk_en)         model_step = (model_step + 1) % BUDGET;
    end

    always @(negedge clk) begin
        if (model_step >= 0 && !done) begin
            string tag;
            tag = last_rst ? "R1" : (last_ce ? "R2" : "R5");
            check(tag, "step", int'(step), model_step);
            check(last_rst ? "R1" : "R6", "sample_start", int'(sample_start),
                  (model_step == 0) ? 1 : 0);
            for (int u = 0; u < UNITS; u++) begin
                check(last_rst ? "R1" : "R3_R4", $sformatf("unit_en[%0d]", u), int'(unit_en[u]),
                      (model_step >= win_lo[u] && model_step <= win_hi[u]) ? 1 : 0);
            end
        end
    end

    task automatic run(input int cycles, input int pattern);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            rst = 1'b0;
            case (pattern)
                0: clk_en = 1'b1;
                1: clk_en = ((k % 3) != 0);
                2: clk_en = 1'b0;
                default: clk_en = ((k % 5) < 2);
            endcase
        end
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1;
        clk_en = 1'b0;
        repeat (3) @(negedge clk);
        run(2 * BUDGET + 7, 0);   // R2 wrap, R6 pulse period
        run(3 * BUDGET, 1);       // R5 holds at many boundaries
        run(12, 2);               // R5 long freeze
        run(2 * BUDGET, 3);
        run(13, 0);
        @(negedge clk);           // R1 reset in the middle of a lap
        rst = 1'b1;
        clk_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        run(BUDGET + 5, 0);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule